// File: doc/BRIEF.md
# Adaptive-Threshold Dual-Bandwidth Voltage-Loop PI Regulator

This block is the outer voltage loop of a digitally controlled power-factor-correcting rectifier. On every sample strobe it forms the signed error between a reference code and an 8-bit output-voltage code. It then updates an incremental PI law, u[n] = u[n-1] + K*(e[n] - a*e[n-1]), and presents the result as the loop output. The output-voltage code is fine enough that the twice-line-frequency capacitor ripple spans several codes, so the error is seldom zero even in steady state.

To keep that ripple out of the loop while still reacting quickly to load steps, a magnitude comparator checks |e[n]| against a threshold. At or below the threshold the regulator uses a slow coefficient pair, which gives a loop crossover in the 10 to 20 Hz range. Above it, the regulator uses a fast pair. Only K and a change between the two modes. The stored output and the previous error carry straight across a switch, so the output has no jump.

The threshold tracks the ripple actually present. The block rectifies the error, sums it over a block of N = 2^LOG2N samples, takes the block mean by a right shift, and adds a small constant margin. Until the first block is complete, a threshold supplied from outside is used instead. A threshold state machine (states TH_PRIME and TH_TRACK; PRIME to TRACK on the last sample of the first block, TRACK holds) governs this. A band state machine (states BAND_SLOW and BAND_FAST; SLOW to FAST on a sample whose magnitude exceeds the threshold, FAST to SLOW on a sample whose magnitude does not) drives the exported mode flag.

Top module: `vloop_dualband_pi`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, u_out is 0 and fast_mode is 0. The stored previous error is 0 and the threshold in force is th_init.
- R2: The error is vref minus vcode, formed as a signed 9-bit value (both codes unsigned 8-bit), and its magnitude is the absolute value in 8 bits, so a code above the reference gives a negative error.
- R3: A sample whose magnitude is strictly greater than the threshold in force uses k_fast/a_fast and sets fast_mode. A sample whose magnitude is less than or equal to it uses k_slow/a_slow and clears fast_mode.
- R4: On a sample, u_out becomes u_prev + ((K * (e - ((a * e_prev) >>> 7))) >>> 4). K is unsigned with 4 fractional bits, a is unsigned with 7 fractional bits, and both shifts are arithmetic, so they round toward minus infinity.
- R5: u_out is a signed 16-bit value that saturates at +32767 and -32768 instead of wrapping.
- R6: In a cycle without sample_en, u_out, fast_mode, the previous error, the threshold and the block accumulator all keep their values whatever vcode and vref do.
- R7: The previous error used by a sample is the error of the preceding sample, even when that sample ran in the other mode. A mode switch leaves u_out continuous.
- R8: Until N samples have been taken after reset, the threshold in force is th_init.
- R9: On the last sample of each block of N, the new threshold becomes floor(sum of the block's magnitudes / N) + MARGIN, saturated at 255. The block sum then restarts from zero.
- R10: The sample that completes a block is compared against the old threshold. The new threshold applies from the next sample.
- R11: u_out and fast_mode take their new values at the clock edge where sample_en is high, and are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle strobe marking a new voltage sample |
| vcode | input | 8 | Measured output-voltage code |
| vref | input | 8 | Reference code |
| k_slow | input | 8 | Gain K for the slow mode, unsigned Q4.4 |
| a_slow | input | 8 | Zero coefficient a for the slow mode, unsigned Q1.7 |
| k_fast | input | 8 | Gain K for the fast mode, unsigned Q4.4 |
| a_fast | input | 8 | Zero coefficient a for the fast mode, unsigned Q1.7 |
| th_init | input | 8 | Threshold used before the first block completes |
| u_out | output | 16 | Signed regulator output u[n] |
| fast_mode | output | 1 | High while the fast coefficient pair is in use |

## Verification
The bench builds the regulator with LOG2N = 2 and MARGIN = 2. Blocks are then four samples long, so the first adaptation comes after the fourth sample, and the bench can steer the threshold to exact values such as 6 and 8 with short error patterns. This puts the equality edge of the comparator and the old-versus-new threshold ordering at the end of a block within a few samples. The fast gain can be set to its largest code with a zero coefficient of zero, so both saturation rails are reached within about twenty samples.

// File: rtl/vloop_pkg.sv
package vloop_pkg;

    typedef enum logic {
        BAND_SLOW = 1'b0,
        BAND_FAST = 1'b1
    } band_e;

    typedef enum logic {
        TH_PRIME = 1'b0,
        TH_TRACK = 1'b1
    } thr_e;

endpackage

// File: rtl/vloop_err_front.sv
module vloop_err_front #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0]      vcode,
    input  logic [CODE_W-1:0]      vref,
    output logic signed [CODE_W:0] err,
    output logic [CODE_W-1:0]      mag
);

    logic signed [CODE_W:0] ref_s;
    logic signed [CODE_W:0] code_s;
    logic signed [CODE_W:0] neg;

    always_comb begin
        ref_s  = $signed({1'b0, vref});
        code_s = $signed({1'b0, vcode});
        err    = ref_s - code_s;
        neg    = -err;
        if (err[CODE_W]) begin
            mag = neg[CODE_W-1:0];
        end else begin
            mag = err[CODE_W-1:0];
        end
    end

endmodule

// File: rtl/vloop_th_tracker.sv
module vloop_th_tracker
    import vloop_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int LOG2N  = 3,
    parameter int MARGIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [CODE_W-1:0] mag,
    input  logic [CODE_W-1:0] th_init,
    output logic [CODE_W-1:0] th_live
);

    localparam int SUM_W = CODE_W + LOG2N;
    localparam logic [LOG2N-1:0] CNT_LAST = {LOG2N{1'b1}};
    localparam logic [CODE_W:0] MARGIN_V = (CODE_W+1)'(MARGIN);
    localparam logic [CODE_W:0] TH_CAP = {1'b0, {CODE_W{1'b1}}};

    thr_e state_q;
    thr_e state_d;

    logic [LOG2N-1:0]  cnt_q;
    logic [SUM_W-1:0]  acc_q;
    logic [CODE_W-1:0] th_q;
    logic [SUM_W-1:0]  sum_full;
    logic [SUM_W-1:0]  sum_shift;
    logic [CODE_W:0]   th_raw;
    logic [CODE_W-1:0] th_new;
    logic              block_end;

    always_comb begin
        block_end = sample_en && (cnt_q == CNT_LAST);
        sum_full  = acc_q + SUM_W'(mag);
        sum_shift = sum_full >> LOG2N;
        th_raw    = {1'b0, sum_shift[CODE_W-1:0]} + MARGIN_V;
        if (th_raw > TH_CAP) begin
            th_new = TH_CAP[CODE_W-1:0];
        end else begin
            th_new = th_raw[CODE_W-1:0];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_PRIME: if (block_end) state_d = TH_TRACK;
            TH_TRACK: state_d = TH_TRACK;
            default:  state_d = TH_PRIME;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TH_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
            th_q  <= '0;
        end else if (sample_en) begin
            cnt_q <= cnt_q + 1'b1;
            if (block_end) begin
                acc_q <= '0;
                th_q  <= th_new;
            end else begin
                acc_q <= sum_full;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            TH_PRIME: th_live = th_init;
            TH_TRACK: th_live = th_q;
            default:  th_live = th_init;
        endcase
    end

endmodule

// File: rtl/vloop_band_fsm.sv
module vloop_band_fsm
    import vloop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic exceed,
    output logic fast_mode
);

    band_e state_q;
    band_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BAND_SLOW: if (sample_en && exceed)  state_d = BAND_FAST;
            BAND_FAST: if (sample_en && !exceed) state_d = BAND_SLOW;
            default:   state_d = BAND_SLOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BAND_SLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            BAND_SLOW: fast_mode = 1'b0;
            BAND_FAST: fast_mode = 1'b1;
            default:   fast_mode = 1'b0;
        endcase
    end

endmodule

// File: rtl/vloop_pi_core.sv
module vloop_pi_core #(
    parameter int CODE_W = 8,
    parameter int COEF_W = 8,
    parameter int K_FRAC = 4,
    parameter int A_FRAC = 7,
    parameter int U_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  logic signed [CODE_W:0]  err,
    input  logic [COEF_W-1:0]       k_sel,
    input  logic [COEF_W-1:0]       a_sel,
    output logic signed [U_W-1:0]   u
);

    localparam int W = U_W + 2*COEF_W + CODE_W + 4;
    localparam logic signed [W-1:0] UMAX = W'((64'sd1 <<< (U_W-1)) - 64'sd1);
    localparam logic signed [W-1:0] UMIN = -UMAX - W'(1);

    logic signed [CODE_W:0] ep_q;
    logic signed [U_W-1:0]  u_q;
    logic signed [W-1:0]    e_w, ep_w, u_w, k_w, a_w;
    logic signed [W-1:0]    ae, diff, inc, sum, u_nx;

    always_comb begin
        e_w  = {{(W-CODE_W-1){err[CODE_W]}}, err};
        ep_w = {{(W-CODE_W-1){ep_q[CODE_W]}}, ep_q};
        u_w  = {{(W-U_W){u_q[U_W-1]}}, u_q};
        k_w  = {{(W-COEF_W){1'b0}}, k_sel};
        a_w  = {{(W-COEF_W){1'b0}}, a_sel};
        ae   = (a_w * ep_w) >>> A_FRAC;
        diff = e_w - ae;
        inc  = (k_w * diff) >>> K_FRAC;
        sum  = u_w + inc;
        if (sum > UMAX) begin
            u_nx = UMAX;
        end else if (sum < UMIN) begin
            u_nx = UMIN;
        end else begin
            u_nx = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_q  <= '0;
            ep_q <= '0;
        end else if (sample_en) begin
            u_q  <= u_nx[U_W-1:0];
            ep_q <= err;
        end
    end

    assign u = u_q;

endmodule

// File: rtl/vloop_dualband_pi.sv
module vloop_dualband_pi #(
    parameter int CODE_W = 8,
    parameter int COEF_W = 8,
    parameter int K_FRAC = 4,
    parameter int A_FRAC = 7,
    parameter int U_W    = 16,
    parameter int LOG2N  = 3,
    parameter int MARGIN = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_en,
    input  logic [CODE_W-1:0]     vcode,
    input  logic [CODE_W-1:0]     vref,
    input  logic [COEF_W-1:0]     k_slow,
    input  logic [COEF_W-1:0]     a_slow,
    input  logic [COEF_W-1:0]     k_fast,
    input  logic [COEF_W-1:0]     a_fast,
    input  logic [CODE_W-1:0]     th_init,
    output logic signed [U_W-1:0] u_out,
    output logic                  fast_mode
);

    logic signed [CODE_W:0] err;
    logic [CODE_W-1:0]      err_mag;
    logic [CODE_W-1:0]      th_live;
    logic                   exceed;
    logic [COEF_W-1:0]      k_sel;
    logic [COEF_W-1:0]      a_sel;

    vloop_err_front #(.CODE_W(CODE_W)) u_front (
        .vcode (vcode),
        .vref  (vref),
        .err   (err),
        .mag   (err_mag)
    );

    vloop_th_tracker #(
        .CODE_W (CODE_W),
        .LOG2N  (LOG2N),
        .MARGIN (MARGIN)
    ) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .mag       (err_mag),
        .th_init   (th_init),
        .th_live   (th_live)
    );

    always_comb begin
        exceed = err_mag > th_live;
        if (exceed) begin
            k_sel = k_fast;
            a_sel = a_fast;
        end else begin
            k_sel = k_slow;
            a_sel = a_slow;
        end
    end

    vloop_band_fsm u_band (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .exceed    (exceed),
        .fast_mode (fast_mode)
    );

    vloop_pi_core #(
        .CODE_W (CODE_W),
        .COEF_W (COEF_W),
        .K_FRAC (K_FRAC),
        .A_FRAC (A_FRAC),
        .U_W    (U_W)
    ) u_pi (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .err       (err),
        .k_sel     (k_sel),
        .a_sel     (a_sel),
        .u         (u_out)
    );

endmodule

// File: rtl/vloop_dualband_pi_chk.sv
module vloop_dualband_pi_chk #(
    parameter int CODE_W = 8,
    parameter int U_W    = 16,
    parameter int LOG2N  = 3,
    parameter int MARGIN = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sample_en,
    input logic [CODE_W-1:0]     err_mag,
    input logic [CODE_W-1:0]     th_live,
    input logic [CODE_W-1:0]     th_init,
    input logic signed [U_W-1:0] u_out,
    input logic                  fast_mode
);

    localparam int N = 1 << LOG2N;
    localparam int TH_FLOOR = (MARGIN > ((1 << CODE_W) - 1)) ? ((1 << CODE_W) - 1) : MARGIN;

    int seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 0;
        end else if (sample_en && seen_q < N) begin
            seen_q <= seen_q + 1;
        end
    end

    // R3: a magnitude above the threshold selects the fast band
    p_fast_on_exceed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && (err_mag > th_live)) |=> fast_mode);

    // R3: a magnitude at or below the threshold selects the slow band
    p_slow_within_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && (err_mag <= th_live)) |=> !fast_mode);

    // R6: no strobe, no change of output
    p_hold_u_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(u_out));

    // R6: no strobe, no change of mode
    p_hold_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(fast_mode));

    // R8: the external threshold rules until the first block completes
    p_warmup_th_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q < N) |-> (th_live == th_init));

    // R9: an adapted threshold never falls below the margin
    p_th_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q >= N) |-> (int'(th_live) >= TH_FLOOR));

endmodule

bind vloop_dualband_pi vloop_dualband_pi_chk #(
    .CODE_W (CODE_W),
    .U_W    (U_W),
    .LOG2N  (LOG2N),
    .MARGIN (MARGIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .err_mag   (err_mag),
    .th_live   (th_live),
    .th_init   (th_init),
    .u_out     (u_out),
    .fast_mode (fast_mode)
);

// File: tb/vloop_dualband_pi_tb.sv
`timescale 1ns/1ps
module vloop_dualband_pi_tb;

    localparam int LOG2N  = 2;
    localparam int N      = 1 << LOG2N;
    localparam int MARGIN = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_en = 1'b0;
    logic [7:0]        vcode = 8'd128;
    logic [7:0]        vref = 8'd128;
    logic [7:0]        k_slow = 8'd16;
    logic [7:0]        a_slow = 8'd120;
    logic [7:0]        k_fast = 8'd64;
    logic [7:0]        a_fast = 8'd96;
    logic [7:0]        th_init = 8'd10;
    logic signed [15:0] u_out;
    logic              fast_mode;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural reference state
    int  m_u = 0, m_ep = 0, m_th = 0, m_acc = 0, m_cnt = 0;
    bit  m_fast = 1'b0, m_warm = 1'b1;

    vloop_dualband_pi #(.LOG2N(LOG2N), .MARGIN(MARGIN)) u_dut (
        .clk (clk), .rst_n (rst_n), .sample_en (sample_en),
        .vcode (vcode), .vref (vref),
        .k_slow (k_slow), .a_slow (a_slow), .k_fast (k_fast), .a_fast (a_fast),
        .th_init (th_init), .u_out (u_out), .fast_mode (fast_mode)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_sample();
        int e, mag, th_use, k, a, ae, diff, inc, nu, t;
        bit ex;
        e = int'(vref) - int'(vcode);
        mag = (e < 0) ? -e : e;
        th_use = m_warm ? int'(th_init) : m_th;
        ex = mag > th_use;
        k = ex ? int'(k_fast) : int'(k_slow);
        a = ex ? int'(a_fast) : int'(a_slow);
        ae = (a * m_ep) >>> 7;
        diff = e - ae;
        inc = (k * diff) >>> 4;
        nu = m_u + inc;
        if (nu > 32767) nu = 32767;
        if (nu < -32768) nu = -32768;
        m_u = nu;
        m_ep = e;
        m_fast = ex;
        if (m_cnt == N - 1) begin
            t = ((m_acc + mag) >>> LOG2N) + MARGIN;
            if (t > 255) t = 255;
            m_th = t;
            m_warm = 1'b0;
            m_acc = 0;
            m_cnt = 0;
        end else begin
            m_acc += mag;
            m_cnt++;
        end
    endtask

    // one clock: model follows the edge, compare away from the edge (R11)
    task automatic tick(input string tag);
        @(posedge clk);
        if (sample_en) model_sample();
        @(negedge clk);
        check(int'(u_out) == m_u, {tag, " u_out"}, int'(u_out), m_u);
        check(fast_mode == m_fast, {tag, " fast_mode"}, int'(fast_mode), int'(m_fast));
    endtask

    task automatic samp(input int code, input int refv, input string tag);
        vcode = 8'(code);
        vref = 8'(refv);
        sample_en = 1'b1;
        tick(tag);
        sample_en = 1'b0;
    endtask

    int held;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(u_out == 16'sd0, "R1 reset u_out", int'(u_out), 0);
        check(fast_mode == 1'b0, "R1 reset fast_mode", int'(fast_mode), 0);
        rst_n = 1'b1;
        tick("R1 first cycle");

        // R8 / R4 / R2: warm-up with th_init = 10
        samp(127, 128, "R4 e=+1");
        check(u_out == 16'sd1, "R4 hand value 1", int'(u_out), 1);
        samp(129, 128, "R2 negative error");
        check(u_out == 16'sd0, "R2 hand value 0", int'(u_out), 0);
        samp(126, 128, "R4 floor of a*e_prev");
        check(u_out == 16'sd3, "R4 hand value 3", int'(u_out), 3);
        check(fast_mode == 1'b0, "R8 below th_init stays slow", int'(fast_mode), 0);
        samp(140, 128, "R8 above th_init");
        check(fast_mode == 1'b1, "R8 mag 12 over th_init 10", int'(fast_mode), 1);
        check(u_out == -16'sd49, "R7 fast sample uses slow e_prev", int'(u_out), -49);

        // R6: inputs move without a strobe
        held = int'(u_out);
        for (int i = 0; i < 5; i++) begin
            vcode = 8'(i * 37);
            vref = 8'(255 - i * 11);
            tick("R6 idle");
        end
        check(int'(u_out) == held, "R6 output held", int'(u_out), held);
        check(fast_mode == 1'b1, "R6 mode held", int'(fast_mode), 1);

        // R9 / R10: threshold is now 4 + 2 = 6
        samp(122, 128, "R9 mag 6");
        check(fast_mode == 1'b0, "R9 mag equal to threshold 6", int'(fast_mode), 0);
        samp(135, 128, "R9 mag 7");
        check(fast_mode == 1'b1, "R9 mag 7 over threshold 6", int'(fast_mode), 1);
        samp(123, 128, "R9 mag 5");
        samp(134, 128, "R10 block end mag 6");
        check(fast_mode == 1'b0, "R10 block end uses old threshold", int'(fast_mode), 0);
        samp(120, 128, "R10 mag 8");
        check(fast_mode == 1'b0, "R10 mag 8 equal to new threshold 8", int'(fast_mode), 0);
        samp(137, 128, "R10 mag 9");
        check(fast_mode == 1'b1, "R10 mag 9 over new threshold 8", int'(fast_mode), 1);

        // R7: alternating modes, continuity against the model
        for (int i = 0; i < 12; i++) begin
            samp((i % 2 == 0) ? 126 : 150, 128, "R7 alternate");
        end

        // R5: both rails
        k_slow = 8'd255; a_slow = 8'd0; k_fast = 8'd255; a_fast = 8'd0;
        for (int i = 0; i < 12; i++) samp(0, 255, "R5 climb");
        check(u_out == 16'sd32767, "R5 positive rail", int'(u_out), 32767);
        for (int i = 0; i < 24; i++) samp(255, 0, "R5 fall");
        check(u_out == -16'sd32768, "R5 negative rail", int'(u_out), -32768);

        // R3: mixed pattern with ordinary coefficients
        k_slow = 8'd16; a_slow = 8'd120; k_fast = 8'd64; a_fast = 8'd96;
        for (int i = 0; i < 20; i++) begin
            samp(128 + ((i * 7) % 13) - 6, 128, "R3 ripple");
            tick("R6 gap");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule